// File: doc/BRIEF.md
# Transmit Underflow Recovery Controller

This block decides what a transmitter does when its data FIFO runs dry in the middle of a frame. A single configuration bit selects the reaction. With the bit clear, the underflow switches the transmitter off and transmission stays halted until a new start command. With the bit set, the transmitter stays on. The controller walks forward through the transmit descriptor ring from the descriptor that was in use and returns to the host every remaining descriptor of the broken frame. It stops at the first descriptor that begins a new frame and reports that index so that transmission can resume there.

The controller reads the ring through a simple fetch port. It presents an index, and the surrounding logic answers with a valid strobe together with the descriptor's start-of-frame and ownership flags. A descriptor that the host still owns stalls the walk at that index. Every underflow seen while the transmitter is on sets a sticky error flag. The block does not move any frame data.

Top module: `txuf_recover`

## Requirements
- R1: After `rst_n` is released, `tx_on`, `uflow_err`, `fetch_req`, `rel_vld` and `restart_vld` are all 0, and the configuration bit is 0, which selects halt mode.
- R2: In halt mode (configuration bit 0), an `uflow` pulse while `tx_on` is 1 clears `tx_on` at the next clock edge, and no ring fetch follows.
- R3: Each `uflow` pulse while `tx_on` is 1 sets `uflow_err` at the next edge in both modes. The flag then holds until `err_clr`, and a set in the same cycle wins over a clear.
- R4: In recovery mode (configuration bit 1), an `uflow` pulse while `tx_on` is 1 and no walk is running leaves `tx_on` at 1. From the next cycle on, it raises `fetch_req` with `fetch_idx` set to the ring entry after `cur_idx`.
- R5: A fetched descriptor with own=1 and sof=0 gives a one-cycle `rel_vld` pulse in the next cycle, with `rel_idx` equal to that index, and the walk moves to the following entry.
- R6: A fetched descriptor with own=1 and sof=1 gives a one-cycle `restart_vld` pulse in the next cycle, with `restart_idx` equal to that index, and it ends the walk (`fetch_req` returns to 0).
- R7: The entry after index RING_LEN-1 is index 0.
- R8: A fetched descriptor with own=0 keeps `fetch_idx` unchanged and `fetch_req` high. The same entry is fetched again every cycle until it is owned.
- R9: The configuration bit is cleared by `rst_n` low and by `soft_rst`. `stop_cmd` leaves it unchanged.
- R10: `stop_cmd` clears `tx_on` at the next edge and abandons any walk in progress.
- R11: An `uflow` pulse while `tx_on` is 0 has no effect. `uflow_err` does not change and no walk starts.
- R12: `start_cmd` sets `tx_on` at the next edge, unless `stop_cmd`, `soft_rst` or a halting underflow occurs in the same cycle.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stop_cmd | input | 1 | Stop the transmitter |
| start_cmd | input | 1 | Turn the transmitter on |
| cfg_we | input | 1 | Write strobe for the configuration bit |
| cfg_recover | input | 1 | Configuration value: 1 selects recovery, 0 selects halt |
| uflow | input | 1 | FIFO underflow strobe |
| err_clr | input | 1 | Clear the underflow error flag |
| cur_idx | input | IW | Descriptor index in use when the underflow occurs |
| fetch_req | output | 1 | A descriptor fetch is wanted |
| fetch_idx | output | IW | Index of the descriptor to fetch |
| fetch_vld | input | 1 | Fetch answer is valid |
| fetch_sof | input | 1 | The fetched descriptor starts a frame |
| fetch_own | input | 1 | The controller owns the fetched descriptor |
| rel_vld | output | 1 | Pulse: a skipped descriptor is returned with error |
| rel_idx | output | IW | Index of the returned descriptor |
| restart_vld | output | 1 | Pulse: transmission resumes |
| restart_idx | output | IW | Descriptor index where transmission resumes |
| tx_on | output | 1 | The transmitter is on |
| uflow_err | output | 1 | Sticky underflow error flag |

## Verification
The hardest situation to reach is a walk that stalls on a descriptor the host still owns and then has to continue correctly once ownership arrives. A second hard case is a walk that wraps all the way around the ring to the entry just before its start. The bench models the ring as per-entry start and ownership masks and answers fetches from them. It first withholds ownership of one entry and holds the answer there for several cycles, then grants ownership in the middle of the walk. It also uses a ring whose only start descriptor is the one that underflowed, which forces seven skips and a wrap through index 0.

// File: rtl/txuf_pkg.sv
package txuf_pkg;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_WALK = 1'b1
  } walk_st_e;

  typedef enum logic [1:0] {
    DV_NONE = 2'd0,
    DV_WAIT = 2'd1,
    DV_SKIP = 2'd2,
    DV_HIT  = 2'd3
  } desc_verdict_e;

  // Classify one fetch answer.
  function automatic desc_verdict_e judge_desc(input logic vld, input logic own,
                                               input logic sof);
    if (!vld)      return DV_NONE;
    else if (!own) return DV_WAIT;
    else if (!sof) return DV_SKIP;
    else           return DV_HIT;
  endfunction

endpackage

// File: rtl/txuf_cfg.sv
module txuf_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic cfg_we,
  input  logic cfg_din,
  output logic cfg_q
);

  // Hard and soft reset clear the mode bit; stop has no path here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= 1'b0;
    else if (soft_rst) cfg_q <= 1'b0;
    else if (cfg_we)   cfg_q <= cfg_din;
  end

endmodule

// File: rtl/txuf_txctl.sv
module txuf_txctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic stop_cmd,
  input  logic start_cmd,
  input  logic ev_uflow,
  input  logic ev_halt,
  input  logic err_clr,
  output logic tx_on,
  output logic uflow_err
);

  // Priority: soft reset, stop, halting underflow, start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_on <= 1'b0;
    else if (soft_rst)  tx_on <= 1'b0;
    else if (stop_cmd)  tx_on <= 1'b0;
    else if (ev_halt)   tx_on <= 1'b0;
    else if (start_cmd) tx_on <= 1'b1;
  end

  // A new underflow wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        uflow_err <= 1'b0;
    else if (soft_rst) uflow_err <= 1'b0;
    else if (ev_uflow) uflow_err <= 1'b1;
    else if (err_clr)  uflow_err <= 1'b0;
  end

endmodule

// File: rtl/txuf_walk.sv
module txuf_walk
  import txuf_pkg::*;
#(
  parameter int RING_LEN = 8,
  localparam int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          ev_recover,
  input  logic [IW-1:0] cur_idx,
  input  logic          fetch_vld,
  input  logic          fetch_own,
  input  logic          fetch_sof,
  output logic          fetch_req,
  output logic [IW-1:0] fetch_idx,
  output logic          rel_vld,
  output logic [IW-1:0] rel_idx,
  output logic          restart_vld,
  output logic [IW-1:0] restart_idx,
  output logic          walking
);

  localparam logic [IW-1:0] LAST_IDX = IW'(RING_LEN - 1);

  // Following ring entry, wrapping after the last one.
  function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] i);
    if (i == LAST_IDX) return '0;
    else               return i + IW'(1);
  endfunction

  walk_st_e      st_q;
  logic [IW-1:0] idx_q;
  desc_verdict_e verdict;

  assign verdict   = judge_desc(fetch_vld, fetch_own, fetch_sof);
  assign walking   = (st_q == SC_WALK);
  assign fetch_req = walking;
  assign fetch_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SC_IDLE;
      idx_q <= '0;
    end else if (abort) begin
      st_q <= SC_IDLE;
    end else begin
      unique case (st_q)
        SC_IDLE: begin
          if (ev_recover) begin
            st_q  <= SC_WALK;
            idx_q <= ring_next(cur_idx);
          end
        end
        SC_WALK: begin
          unique case (verdict)
            DV_SKIP: idx_q <= ring_next(idx_q);
            DV_HIT:  st_q  <= SC_IDLE;
            default: ;
          endcase
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

  // Registered one-cycle pulses for returned and restart descriptors.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_vld     <= 1'b0;
      rel_idx     <= '0;
      restart_vld <= 1'b0;
      restart_idx <= '0;
    end else begin
      rel_vld     <= 1'b0;
      restart_vld <= 1'b0;
      if (!abort && walking) begin
        if (verdict == DV_SKIP) begin
          rel_vld <= 1'b1;
          rel_idx <= idx_q;
        end
        if (verdict == DV_HIT) begin
          restart_vld <= 1'b1;
          restart_idx <= idx_q;
        end
      end
    end
  end

endmodule

// File: rtl/txuf_recover.sv
module txuf_recover
  import txuf_pkg::*;
#(
  parameter int RING_LEN = 8,
  localparam int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          stop_cmd,
  input  logic          start_cmd,
  input  logic          cfg_we,
  input  logic          cfg_recover,
  input  logic          uflow,
  input  logic          err_clr,
  input  logic [IW-1:0] cur_idx,
  output logic          fetch_req,
  output logic [IW-1:0] fetch_idx,
  input  logic          fetch_vld,
  input  logic          fetch_sof,
  input  logic          fetch_own,
  output logic          rel_vld,
  output logic [IW-1:0] rel_idx,
  output logic          restart_vld,
  output logic [IW-1:0] restart_idx,
  output logic          tx_on,
  output logic          uflow_err
);

  logic cfg_q;
  logic walking;
  logic ev_uflow;
  logic ev_halt;
  logic ev_recover;
  logic ev_abort;

  // Named internal events.
  assign ev_uflow   = uflow & tx_on;
  assign ev_halt    = ev_uflow & ~cfg_q;
  assign ev_recover = ev_uflow & cfg_q & ~walking;
  assign ev_abort   = soft_rst | stop_cmd;

  txuf_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .cfg_we   (cfg_we),
    .cfg_din  (cfg_recover),
    .cfg_q    (cfg_q)
  );

  txuf_txctl u_txctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .stop_cmd  (stop_cmd),
    .start_cmd (start_cmd),
    .ev_uflow  (ev_uflow),
    .ev_halt   (ev_halt),
    .err_clr   (err_clr),
    .tx_on     (tx_on),
    .uflow_err (uflow_err)
  );

  txuf_walk #(.RING_LEN(RING_LEN)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort       (ev_abort),
    .ev_recover  (ev_recover),
    .cur_idx     (cur_idx),
    .fetch_vld   (fetch_vld),
    .fetch_own   (fetch_own),
    .fetch_sof   (fetch_sof),
    .fetch_req   (fetch_req),
    .fetch_idx   (fetch_idx),
    .rel_vld     (rel_vld),
    .rel_idx     (rel_idx),
    .restart_vld (restart_vld),
    .restart_idx (restart_idx),
    .walking     (walking)
  );

endmodule

// File: rtl/txuf_recover_chk.sv
module txuf_recover_chk #(
  parameter int RING_LEN = 8,
  localparam int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          stop_cmd,
  input logic          uflow,
  input logic [IW-1:0] cur_idx,
  input logic          cfg_q,
  input logic          fetch_req,
  input logic [IW-1:0] fetch_idx,
  input logic          fetch_vld,
  input logic          fetch_sof,
  input logic          fetch_own,
  input logic          rel_vld,
  input logic [IW-1:0] rel_idx,
  input logic          restart_vld,
  input logic [IW-1:0] restart_idx,
  input logic          tx_on,
  input logic          uflow_err
);

  localparam logic [IW-1:0] TOP_IDX = IW'(RING_LEN - 1);

  function automatic logic [IW-1:0] after_idx(input logic [IW-1:0] i);
    return (i == TOP_IDX) ? '0 : IW'(i + IW'(1));
  endfunction

  logic quiet;
  assign quiet = !stop_cmd && !soft_rst;

  AST_HALT_DROPS_TXON: assert property (@(posedge clk) disable iff (!rst_n)
    uflow && tx_on && !cfg_q && !soft_rst |=> !tx_on && !fetch_req); // R2
  AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    uflow && tx_on && !soft_rst |=> uflow_err); // R3
  AST_RECOVER_START: assert property (@(posedge clk) disable iff (!rst_n)
    uflow && tx_on && cfg_q && !fetch_req && quiet
    |=> tx_on && fetch_req && fetch_idx == after_idx($past(cur_idx))); // R4
  AST_REQ_NEEDS_TXON: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> tx_on); // R4
  AST_SKIP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_vld && fetch_own && !fetch_sof && quiet
    |=> rel_vld && rel_idx == $past(fetch_idx)); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rel_vld, restart_vld})); // R5
  AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_vld && fetch_own && fetch_sof && quiet
    |=> restart_vld && restart_idx == $past(fetch_idx) && !fetch_req); // R6
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_vld && fetch_own && !fetch_sof && fetch_idx == TOP_IDX && quiet
    |=> fetch_idx == '0); // R7
  AST_POLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_vld && !fetch_own && quiet
    |=> fetch_req && $stable(fetch_idx)); // R8
  AST_SOFT_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !cfg_q); // R9
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !tx_on && !fetch_req); // R10
  AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    uflow && !tx_on |=> !fetch_req); // R11

endmodule

bind txuf_recover txuf_recover_chk #(.RING_LEN(RING_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .stop_cmd    (stop_cmd),
  .uflow       (uflow),
  .cur_idx     (cur_idx),
  .cfg_q       (cfg_q),
  .fetch_req   (fetch_req),
  .fetch_idx   (fetch_idx),
  .fetch_vld   (fetch_vld),
  .fetch_sof   (fetch_sof),
  .fetch_own   (fetch_own),
  .rel_vld     (rel_vld),
  .rel_idx     (rel_idx),
  .restart_vld (restart_vld),
  .restart_idx (restart_idx),
  .tx_on       (tx_on),
  .uflow_err   (uflow_err)
);

// File: tb/test_txuf_recover.sv
`timescale 1ns/1ps
module test_txuf_recover;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, stop_cmd = 1'b0, start_cmd = 1'b0;
  logic       cfg_we = 1'b0, cfg_recover = 1'b0, uflow = 1'b0, err_clr = 1'b0;
  logic [2:0] cur_idx = '0;
  logic       fetch_req, fetch_vld = 1'b0, fetch_sof = 1'b0, fetch_own = 1'b0;
  logic [2:0] fetch_idx, rel_idx, restart_idx;
  logic       rel_vld, restart_vld, tx_on, uflow_err;
  logic [7:0] ring_sof = 8'h00, ring_own = 8'hFF;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  txuf_recover #(.RING_LEN(N)) i_txuf_recover (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
    .start_cmd(start_cmd), .cfg_we(cfg_we), .cfg_recover(cfg_recover),
    .uflow(uflow), .err_clr(err_clr), .cur_idx(cur_idx),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_vld(fetch_vld),
    .fetch_sof(fetch_sof), .fetch_own(fetch_own), .rel_vld(rel_vld),
    .rel_idx(rel_idx), .restart_vld(restart_vld), .restart_idx(restart_idx),
    .tx_on(tx_on), .uflow_err(uflow_err)
  );

  // Ring model: answers a fetch within the cycle it is requested.
  always @(negedge clk) begin
    fetch_vld = fetch_req;
    fetch_sof = ring_sof[fetch_idx];
    fetch_own = ring_own[fetch_idx];
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       mode;
    logic [2:0] cur;
    logic [7:0] sof;
    logic [2:0] rs_idx;
    logic [3:0] skips;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd2, 8'h11, 3'd0, 4'd0},  // halt mode
    '{1'b1, 3'd2, 8'h11, 3'd4, 4'd1},  // one skip
    '{1'b1, 3'd7, 8'h01, 3'd0, 4'd0},  // wrap onto a start
    '{1'b1, 3'd5, 8'h24, 3'd2, 4'd4},  // skips across the wrap
    '{1'b1, 3'd0, 8'h02, 3'd1, 4'd0},  // immediate hit
    '{1'b1, 3'd3, 8'h08, 3'd3, 4'd7}   // full lap
  };

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Start, raise one underflow, then watch the walk for a while.
  task automatic run_case(input logic mode, input logic [2:0] cur,
                          input logic [7:0] sof, input logic [2:0] exp_rs,
                          input int exp_skips);
    int hits = 0, skips = 0, got_rs = -1, last_rel = -1;
    cfg_we = 1'b1; cfg_recover = mode; start_cmd = 1'b1; err_clr = 1'b1;
    ring_sof = sof; ring_own = 8'hFF;
    @(negedge clk);
    cfg_we = 1'b0; start_cmd = 1'b0; err_clr = 1'b0;
    chk("R12 tx_on after start", int'(tx_on), 1);
    cur_idx = cur; uflow = 1'b1;
    @(negedge clk);
    uflow = 1'b0;
    chk("R3 error flag set", int'(uflow_err), 1);
    chk(mode ? "R4 tx_on kept" : "R2 tx_on dropped", int'(tx_on), mode ? 1 : 0);
    if (mode) chk("R4 first fetch index", int'(fetch_idx), (int'(cur) + 1) % N);
    else      chk("R2 no fetch", int'(fetch_req), 0);
    for (int c = 0; c < 20; c++) begin
      if (rel_vld) begin skips++; last_rel = int'(rel_idx); end
      if (restart_vld) begin hits++; got_rs = int'(restart_idx); end
      @(negedge clk);
    end
    chk("R6 restart count", hits, mode ? 1 : 0);
    if (mode) begin
      chk("R6 restart index", got_rs, int'(exp_rs));
      chk("R5 skip count", skips, exp_skips);
      if (exp_skips > 0) chk("R5 last released", last_rel, (int'(exp_rs) + N - 1) % N);
      chk("R6 walk ended", int'(fetch_req), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seen;
    do_reset();
    // R1 reset state
    chk("R1 tx_on", int'(tx_on), 0);
    chk("R1 uflow_err", int'(uflow_err), 0);
    chk("R1 fetch_req", int'(fetch_req), 0);
    chk("R1 rel_vld", int'(rel_vld), 0);
    chk("R1 restart_vld", int'(restart_vld), 0);
    // R1: default mode halts
    start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    uflow = 1'b1; @(negedge clk); uflow = 1'b0;
    chk("R1 default halt", int'(tx_on), 0);

    // R11: underflow while off is ignored
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    cfg_we = 1'b1; cfg_recover = 1'b1; @(negedge clk); cfg_we = 1'b0;
    uflow = 1'b1; @(negedge clk); uflow = 1'b0;
    chk("R11 err unchanged", int'(uflow_err), 0);
    chk("R11 no walk", int'(fetch_req), 0);

    // Vector table
    for (int v = 0; v < NV; v++)
      run_case(VECS[v].mode, VECS[v].cur, VECS[v].sof, VECS[v].rs_idx, int'(VECS[v].skips));

    // R3: flag holds, then clears
    @(negedge clk);
    chk("R3 flag held", int'(uflow_err), 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk("R3 flag cleared", int'(uflow_err), 0);

    // R8: stall on an unowned entry, then release it
    ring_sof = 8'h02; ring_own = 8'hFD;
    cfg_we = 1'b1; cfg_recover = 1'b1; start_cmd = 1'b1; @(negedge clk);
    cfg_we = 1'b0; start_cmd = 1'b0;
    cur_idx = 3'd0; uflow = 1'b1; @(negedge clk); uflow = 1'b0;
    seen = 0;
    for (int c = 0; c < 6; c++) begin
      if (fetch_req && fetch_idx == 3'd1 && !restart_vld) seen++;
      @(negedge clk);
    end
    chk("R8 held at unowned entry", seen, 6);
    ring_own = 8'hFF;
    seen = -1;
    for (int c = 0; c < 5; c++) begin
      if (restart_vld) seen = int'(restart_idx);
      @(negedge clk);
    end
    chk("R8 resumes after ownership", seen, 1);

    // R10: stop abandons a stalled walk
    ring_own = 8'h00;
    start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    cur_idx = 3'd4; uflow = 1'b1; @(negedge clk); uflow = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 walk was stalled", int'(fetch_req), 1);
    stop_cmd = 1'b1; @(negedge clk); stop_cmd = 1'b0;
    chk("R10 tx_on off", int'(tx_on), 0);
    chk("R10 walk dropped", int'(fetch_req), 0);

    // R9: stop leaves the mode bit set
    run_case(1'b1, 3'd3, 8'h01, 3'd0, 4);
    stop_cmd = 1'b1; @(negedge clk); stop_cmd = 1'b0;
    ring_sof = 8'h40; ring_own = 8'hFF;
    start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    cur_idx = 3'd5; uflow = 1'b1; @(negedge clk); uflow = 1'b0;
    chk("R9 mode kept across stop", int'(tx_on), 1);
    repeat (3) @(negedge clk);

    // R9: soft reset clears the mode bit
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    uflow = 1'b1; @(negedge clk); uflow = 1'b0;
    chk("R9 soft reset clears mode", int'(tx_on), 0);

    // R9: hard reset clears the mode bit
    cfg_we = 1'b1; cfg_recover = 1'b1; @(negedge clk); cfg_we = 1'b0;
    do_reset();
    start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
    uflow = 1'b1; @(negedge clk); uflow = 1'b0;
    chk("R9 hard reset clears mode", int'(tx_on), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule